// File: doc/BRIEF.md
# DS3 Transmit Payload Input Interface

This block takes DS3 payload from system-side equipment and delivers it as a single serial bit stream to a downstream transmit framer. The system side supplies data either one bit per clock on a serial pin, or four bits at a time on a nibble bus. All logic runs from one 44.736 MHz bit clock. The choice between the recovered receive clock (loop timing) and a locally supplied clock is made by a clock mux outside the block, which follows the block's `loop_timing` output.

A frame bit counter tracks the position within a 4760-bit DS3 M-frame and drives a one-clock strobe on the last bit of each frame. In nibble modes the block produces a quarter-rate clock enable that tells the system side when its nibble is taken. Two of the six modes slave the frame position to an external frame reference pulse. In the other four modes the frame position runs freely from reset. The mode code is taken only while reset is held.

Top module: `ds3_tx_payload_in`

## Requirements
- R1: While `rst_n` is low at a rising edge, the frame count and nibble phase clear, and `bit_out` is 0 after that edge. `frame_strobe` and `nib_clk_en` are also 0 after that edge.
- R2: `mode_sel` is loaded only at rising edges where `rst_n` is low. Changes to `mode_sel` while `rst_n` is high have no effect on any output.
- R3: `loop_timing` is 1 for mode codes 1 and 4 and 0 for codes 2, 3, 5 and 6. Codes 0 and 7 behave exactly like code 1.
- R4: In the serial modes (codes 1, 2, 3, 0, 7), `bit_out` after each rising edge equals the `ser_din` value sampled at that edge.
- R5: Counting the first edge with `rst_n` high as edge 1, the frame position after edge k is k mod 4760. `frame_strobe` is high for exactly the one clock in which the position is 4759.
- R6: In the nibble modes (codes 4, 5, 6), `nib_clk_en` is high for one clock in every four. It is high when the nibble phase is 3, and the first high clock follows edge 3 after reset.
- R7: In the nibble modes, `nib_din` is captured at each edge where `nib_clk_en` is high. After that edge, `bit_out` shows bit 3, then bit 2, bit 1 and bit 0 on the next four clocks (MSB first). Before the first capture, `bit_out` is 0.
- R8: In codes 2 and 5, a `frame_ref` sampled high at an edge forces the frame position and the nibble phase to 0 after that edge. Counting then resumes from there.
- R9: In codes 1, 3, 4 and 6, `frame_ref` is ignored.
- R10: In the serial modes, `nib_clk_en` stays 0 and `nib_din` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 44.736 MHz bit clock |
| rst_n | input | 1 | Active-low synchronous reset; mode is loaded while low |
| mode_sel | input | 3 | Operating mode code 1..6 (0 and 7 act as 1) |
| ser_din | input | 1 | Serial payload bit |
| nib_din | input | 4 | Nibble payload, bit 3 sent first |
| frame_ref | input | 1 | External frame reference pulse |
| bit_out | output | 1 | Serial payload to the transmit framer |
| frame_strobe | output | 1 | High on the last bit of each frame |
| nib_clk_en | output | 1 | Quarter-rate nibble capture enable |
| loop_timing | output | 1 | Selects the recovered clock in the external clock mux |

## Verification
Each output changes one rising edge after its cause. `bit_out` reflects `ser_din` one edge after sampling, or shows the nibble bits on the four edges after the capture edge. `frame_strobe` rises 4759 edges after reset release or after an accepted reference pulse, and `nib_clk_en` rises 3 edges after either. The bench drives inputs 5 ns after each rising edge and advances a behavioural model at that same edge. It then compares all four outputs on the following falling edge, so every comparison falls in the clock when the result is due. Reference pulses are placed at offsets that are not multiples of four, which shifts the nibble phase and moves the frame strobe.

// File: rtl/ds3_tpi_pkg.sv
package ds3_tpi_pkg;

    localparam int unsigned MODE_W = 3;

    typedef struct packed {
        logic nibble;
        logic loop_tim;
        logic ref_slave;
    } mode_cfg_t;

    function automatic mode_cfg_t decode_mode(input logic [MODE_W-1:0] code);
        mode_cfg_t cfg;
        case (code)
            3'd2:    cfg = '{nibble: 1'b0, loop_tim: 1'b0, ref_slave: 1'b1};
            3'd3:    cfg = '{nibble: 1'b0, loop_tim: 1'b0, ref_slave: 1'b0};
            3'd4:    cfg = '{nibble: 1'b1, loop_tim: 1'b1, ref_slave: 1'b0};
            3'd5:    cfg = '{nibble: 1'b1, loop_tim: 1'b0, ref_slave: 1'b1};
            3'd6:    cfg = '{nibble: 1'b1, loop_tim: 1'b0, ref_slave: 1'b0};
            default: cfg = '{nibble: 1'b0, loop_tim: 1'b1, ref_slave: 1'b0};
        endcase
        return cfg;
    endfunction

endpackage

// File: rtl/ds3_tpi_mode.sv
module ds3_tpi_mode
    import ds3_tpi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    output logic [MODE_W-1:0] mode_code,
    output mode_cfg_t         cfg
);
    logic [MODE_W-1:0] code_d, code_q;

    always_comb begin
        code_d = code_q;
        if (!rst_n) begin
            code_d = mode_sel;
        end
    end

    always_ff @(posedge clk) begin
        code_q <= code_d;
    end

    assign mode_code = code_q;
    assign cfg       = decode_mode(code_q);
endmodule

// File: rtl/ds3_tpi_framer_cnt.sv
module ds3_tpi_framer_cnt #(
    parameter int unsigned FRAME_BITS = 4760,
    parameter int unsigned NIB_W      = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          nibble,
    input  logic                          ref_slave,
    input  logic                          frame_ref,
    output logic [$clog2(FRAME_BITS)-1:0] frame_cnt,
    output logic                          frame_strobe,
    output logic                          nib_clk_en
);
    localparam int unsigned CNT_W = $clog2(FRAME_BITS);
    localparam int unsigned PH_W  = (NIB_W > 1) ? $clog2(NIB_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(NIB_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PH_W-1:0]  ph;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (!rst_n || (ref_slave && frame_ref)) begin
            pos_d = '0;
        end else begin
            pos_d.cnt = (pos_q.cnt == CNT_LAST) ? '0 : pos_q.cnt + 1'b1;
            pos_d.ph  = (pos_q.ph == PH_LAST) ? '0 : pos_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        pos_q <= pos_d;
    end

    assign frame_cnt    = pos_q.cnt;
    assign frame_strobe = (pos_q.cnt == CNT_LAST);
    assign nib_clk_en   = nibble && (pos_q.ph == PH_LAST);
endmodule

// File: rtl/ds3_tpi_serializer.sv
module ds3_tpi_serializer #(
    parameter int unsigned NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nibble,
    input  logic             nib_clk_en,
    input  logic             ser_din,
    input  logic [NIB_W-1:0] nib_din,
    output logic             bit_out
);
    logic [NIB_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (!rst_n) begin
            sh_d = '0;
        end else if (!nibble) begin
            sh_d = {ser_din, {(NIB_W-1){1'b0}}};
        end else if (nib_clk_en) begin
            sh_d = nib_din;
        end else begin
            sh_d = sh_q << 1;
        end
    end

    always_ff @(posedge clk) begin
        sh_q <= sh_d;
    end

    assign bit_out = sh_q[NIB_W-1];
endmodule

// File: rtl/ds3_tx_payload_in.sv
module ds3_tx_payload_in
    import ds3_tpi_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 4760,
    parameter int unsigned NIB_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              ser_din,
    input  logic [NIB_W-1:0]  nib_din,
    input  logic              frame_ref,
    output logic              bit_out,
    output logic              frame_strobe,
    output logic              nib_clk_en,
    output logic              loop_timing
);
    localparam int unsigned CNT_W = $clog2(FRAME_BITS);

    mode_cfg_t         cfg;
    logic [MODE_W-1:0] mode_code;
    logic              nibble_mode;
    logic              ref_slave;
    logic [CNT_W-1:0]  frame_cnt;

    ds3_tpi_mode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .mode_code (mode_code),
        .cfg       (cfg)
    );

    assign nibble_mode = cfg.nibble;
    assign ref_slave   = cfg.ref_slave;
    assign loop_timing = cfg.loop_tim;

    ds3_tpi_framer_cnt #(
        .FRAME_BITS (FRAME_BITS),
        .NIB_W      (NIB_W)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .nibble       (nibble_mode),
        .ref_slave    (ref_slave),
        .frame_ref    (frame_ref),
        .frame_cnt    (frame_cnt),
        .frame_strobe (frame_strobe),
        .nib_clk_en   (nib_clk_en)
    );

    ds3_tpi_serializer #(
        .NIB_W (NIB_W)
    ) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .nibble     (nibble_mode),
        .nib_clk_en (nib_clk_en),
        .ser_din    (ser_din),
        .nib_din    (nib_din),
        .bit_out    (bit_out)
    );
endmodule

// File: rtl/ds3_tx_payload_in_chk.sv
module ds3_tx_payload_in_chk #(
    parameter int unsigned FRAME_BITS = 4760,
    parameter int unsigned MODE_W     = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          ser_din,
    input logic                          frame_ref,
    input logic                          bit_out,
    input logic                          frame_strobe,
    input logic                          nib_clk_en,
    input logic                          nibble_mode,
    input logic                          ref_slave,
    input logic [MODE_W-1:0]             mode_code,
    input logic [$clog2(FRAME_BITS)-1:0] frame_cnt
);
    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_code));

    assert_serial_echo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !nibble_mode |=> (bit_out == $past(ser_din)));

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |=> !frame_strobe);

    assert_wrap_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |=> (frame_cnt == '0));

    assert_count_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_cnt < ($clog2(FRAME_BITS))'(FRAME_BITS));

    assert_nib_en_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nib_clk_en |=> !nib_clk_en);

    assert_ref_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_slave && frame_ref) |=> (frame_cnt == '0));

    assert_serial_no_nib_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !nibble_mode |-> !nib_clk_en);
endmodule

bind ds3_tx_payload_in ds3_tx_payload_in_chk #(
    .FRAME_BITS (FRAME_BITS),
    .MODE_W     (3)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_din      (ser_din),
    .frame_ref    (frame_ref),
    .bit_out      (bit_out),
    .frame_strobe (frame_strobe),
    .nib_clk_en   (nib_clk_en),
    .nibble_mode  (nibble_mode),
    .ref_slave    (ref_slave),
    .mode_code    (mode_code),
    .frame_cnt    (frame_cnt)
);

// File: tb/ds3_tx_payload_in_bench.sv
module ds3_tx_payload_in_bench;
    localparam int FRAME = 4760;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_sel = 3'd1;
    logic       ser_din = 1'b0;
    logic [3:0] nib_din = 4'd0;
    logic       frame_ref = 1'b0;
    logic       bit_out, frame_strobe, nib_clk_en, loop_timing;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ds3_tx_payload_in u_ds3_tx_payload_in (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_sel     (mode_sel),
        .ser_din      (ser_din),
        .nib_din      (nib_din),
        .frame_ref    (frame_ref),
        .bit_out      (bit_out),
        .frame_strobe (frame_strobe),
        .nib_clk_en   (nib_clk_en),
        .loop_timing  (loop_timing)
    );

    // behavioural reference model
    int    m_mode = 1;
    int    m_cnt = 0;
    int    m_ph = 0;
    bit    m_out = 1'b0;
    bit    m_q[$];
    bit    started = 1'b0;
    string tag_bit = "R4";
    string tag_str = "R5";
    string tag_nib = "R10";

    function automatic bit is_nib(int m);
        return (m >= 4 && m <= 6);
    endfunction
    function automatic bit is_slave(int m);
        return (m == 2 || m == 5);
    endfunction
    function automatic bit is_loop(int m);
        return !(m == 2 || m == 3 || m == 5 || m == 6);
    endfunction

    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            m_mode = int'(mode_sel);
            m_cnt  = 0;
            m_ph   = 0;
            m_out  = 1'b0;
            m_q.delete();
        end else begin
            if (!is_nib(m_mode)) begin
                m_out = ser_din;
            end else begin
                if (m_ph == 3) begin
                    m_q.delete();
                    for (int b = 3; b >= 0; b--) m_q.push_back(nib_din[b]);
                end
                m_out = (m_q.size() > 0) ? m_q.pop_front() : 1'b0;
            end
            if (is_slave(m_mode) && frame_ref) begin
                m_cnt = 0;
                m_ph  = 0;
            end else begin
                m_cnt = (m_cnt + 1) % FRAME;
                m_ph  = (m_ph + 1) % 4;
            end
        end
    end

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk(tag_bit, "bit_out", bit_out, m_out);
            chk(tag_str, "frame_strobe", frame_strobe, (m_cnt == FRAME - 1));
            chk(tag_nib, "nib_clk_en", nib_clk_en, is_nib(m_mode) && m_ph == 3);
            chk("R3", "loop_timing", loop_timing, is_loop(m_mode));
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic run_mode(input int code, input int cycles, input int ref_every, input int ref_off);
        @(posedge clk); #5;
        rst_n     = 1'b0;
        mode_sel  = 3'(code);
        frame_ref = 1'b0;
        tag_bit = is_nib(code) ? "R7" : "R4";
        tag_nib = is_nib(code) ? "R6" : "R10";
        tag_str = (ref_every == 0) ? "R5" : (is_slave(code) ? "R8" : "R9");
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state after reset edges
        chk("R1", "bit_out in reset", bit_out, 1'b0);
        chk("R1", "frame_strobe in reset", frame_strobe, 1'b0);
        chk("R1", "nib_clk_en in reset", nib_clk_en, 1'b0);
        @(posedge clk); #5;
        rst_n = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); #5;
            ser_din   = 1'($urandom);
            nib_din   = 4'($urandom);
            frame_ref = (ref_every != 0) && ((i % ref_every) == ref_off);
            if (i == 50) mode_sel = 3'((code + 3) % 8);
        end
        frame_ref = 1'b0;
        @(negedge clk);
        // mode changed while out of reset must not have taken effect
        chk("R2", "loop_timing after mode_sel change", loop_timing, is_loop(code));
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        run_mode(1, 10000, 3001, 1234);
        run_mode(2, 12000, 5000, 2001);
        run_mode(3, 5000, 0, 0);
        run_mode(4, 10000, 2999, 777);
        run_mode(5, 12000, 4003, 1501);
        run_mode(6, 5000, 0, 0);
        run_mode(0, 200, 0, 0);
        run_mode(7, 200, 0, 0);
        summary();
        $finish;
    end
endmodule